// File: doc/BRIEF.md
# Interleaved Cache-Line Fill Memory

This block answers cache-line fill requests from an array spread over four word-interleaved banks. A requester presents a line address. The block broadcasts that address to the banks in one cycle. Each bank then spends a fixed access time reading its word. Word `w` of a line is held in bank `w`, at the row given by the line address. Because all four accesses overlap, only the final word transfers are serialized. They go out one word per cycle on a single-word response bus, in ascending word order, and the final word is marked.

For comparison, the same request can be serviced in a non-interleaved mode. In that mode every word pays the full address, access and transfer cost one after another, as if the line sat in a single bank. The requester picks the mode per request. The block holds off new requests until the final word of the current fill has been sent. The bank arrays are fixed-latency models with a computed content pattern, so a fill can be checked word by word from its address alone.

Top module: `ilv_line_fill`

## Requirements
- R1: During and right after synchronous reset, `fill_ready` is 1, and both `rsp_valid` and `rsp_last` are 0.
- R2: Word `w` (0..3) of line `L` returns the value `{~G[15:0], G[15:0]}`, where `G = 4*L + w`. It is read from bank `w`, row `L`.
- R3: In interleaved mode (`fill_ilv`=1 at acceptance), the four words appear in cycles 8, 9, 10 and 11, counted from the cycle after the accepting clock edge. The fill therefore takes 1 + 6 + 4 = 11 cycles.
- R4: In serial mode (`fill_ilv`=0 at acceptance), word `w` appears alone in cycle 8*(w+1), and `rsp_valid` is 0 in every cycle between words. The fill therefore takes 4 × (1+6+1) = 32 cycles.
- R5: `rsp_idx` carries the word number. Words come in ascending order 0,1,2,3, and `rsp_last` is 1 only together with word 3.
- R6: A request is accepted only in a cycle where `fill_ready` is 1. `fill_ready` stays 0 from the accepting edge until the cycle after the final word. Requests presented while it is 0 are ignored: they produce no response words.
- R7: The mode is sampled only at acceptance. Changing `fill_ilv` or `fill_line` during a fill changes neither its timing nor its data.
- R8: A request presented in the first cycle that `fill_ready` returns to 1 starts a new fill. That fill has the full timing of its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_req | input | 1 | Line fill request |
| fill_line | input | LINE_AW | Line address of the request |
| fill_ilv | input | 1 | 1 selects interleaved service, 0 selects serial service |
| fill_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response word present |
| rsp_data | output | WORD_W | Response word |
| rsp_idx | output | $clog2(NB) | Word number within the line |
| rsp_last | output | 1 | Final word of the line |

## Verification
The hardest situation to reach from the ports is a request that arrives while a fill is running and must leave no trace. The stimulus holds `fill_req` high with a different line and the opposite mode for several cycles right after an acceptance. It then checks two things: the returned stream belongs only to the original line, with the original timing, and no extra words follow once the queue of expected words is empty. A second hard case is a request placed in the very first ready cycle after a fill. The driver waits on `fill_ready` and issues a serial fill immediately after an interleaved one, so both mode latencies are measured back to back.

// File: rtl/ilv_fill_pkg.sv
package ilv_fill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_XFER = 2'd3
  } fill_state_t;

  // Content pattern of the modelled arrays: global word number G gives {~G, G}.
  function automatic logic [31:0] seed_word(input int unsigned gidx);
    logic [15:0] g;
    g = gidx[15:0];
    return {~g, g};
  endfunction

endpackage

// File: rtl/ilv_fill_bank.sv
module ilv_fill_bank #(
  parameter int ROWS_AW = 6,
  parameter int WORD_W  = 32,
  parameter int LAT     = 6,
  parameter int NB      = 4,
  parameter int BANK_ID = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ROWS_AW-1:0] row,
  output logic               vld,
  output logic [WORD_W-1:0]  dat
);
  localparam int ROWS = 1 << ROWS_AW;

  logic [WORD_W-1:0] mem [ROWS];
  logic [WORD_W-1:0] rd_q;

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      mem[r] = WORD_W'(ilv_fill_pkg::seed_word(r * NB + BANK_ID));
    end
  end

  // Synchronous read port, no reset on the data path.
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[row];
  end

  generate
    if (LAT > 1) begin : g_dly
      logic [WORD_W-1:0] d_sr [LAT-1];
      logic [LAT-1:0]    v_sr;

      always_ff @(posedge clk) begin
        d_sr[0] <= rd_q;
        for (int i = 1; i < LAT - 1; i++) d_sr[i] <= d_sr[i-1];
      end

      always_ff @(posedge clk) begin
        if (rst) v_sr <= '0;
        else     v_sr <= {v_sr[LAT-2:0], rd_en};
      end

      assign dat = d_sr[LAT-2];
      assign vld = v_sr[LAT-1];
    end else begin : g_one
      logic v_q;
      always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= rd_en;
      end
      assign dat = rd_q;
      assign vld = v_q;
    end
  endgenerate

endmodule

// File: rtl/ilv_fill_ctrl.sv
module ilv_fill_ctrl #(
  parameter int LINE_AW = 6,
  parameter int WORD_W  = 32,
  parameter int NB      = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fill_req,
  input  logic [LINE_AW-1:0]         fill_line,
  input  logic                       fill_ilv,
  output logic                       fill_ready,
  output logic                       rsp_valid,
  output logic [WORD_W-1:0]          rsp_data,
  output logic [$clog2(NB)-1:0]      rsp_idx,
  output logic                       rsp_last,
  output logic [NB-1:0]              bank_rd,
  output logic [LINE_AW-1:0]         bank_row,
  input  logic [NB-1:0]              bank_vld,
  input  logic [NB-1:0][WORD_W-1:0]  bank_dat
);
  import ilv_fill_pkg::*;

  localparam int IDX_W = $clog2(NB);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

  fill_state_t               state;
  logic [LINE_AW-1:0]        line_q;
  logic                      ilv_q;
  logic [IDX_W-1:0]          widx;
  logic [IDX_W-1:0]          nidx;
  logic [NB-1:0][WORD_W-1:0] buf_q;

  assign nidx     = widx + 1'b1;
  assign bank_row = line_q;

  // Interleaved: every bank reads at once; serial: only the bank of the current word.
  always_comb begin
    bank_rd = '0;
    if (state == ST_ADDR) begin
      if (ilv_q) bank_rd = '1;
      else       bank_rd[widx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      line_q     <= '0;
      ilv_q      <= 1'b0;
      widx       <= '0;
      fill_ready <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_last   <= 1'b0;
      rsp_idx    <= '0;
      rsp_data   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fill_req && fill_ready) begin
            line_q     <= fill_line;
            ilv_q      <= fill_ilv;
            widx       <= '0;
            fill_ready <= 1'b0;
            state      <= ST_ADDR;
          end
        end
        ST_ADDR: state <= ST_WAIT;
        ST_WAIT: begin
          if (bank_vld[widx]) begin
            rsp_valid <= 1'b1;
            rsp_data  <= bank_dat[widx];
            rsp_idx   <= widx;
            rsp_last  <= (widx == LAST_IDX);
            state     <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (widx == LAST_IDX) begin
            rsp_valid  <= 1'b0;
            rsp_last   <= 1'b0;
            fill_ready <= 1'b1;
            state      <= ST_IDLE;
          end else if (ilv_q) begin
            widx     <= nidx;
            rsp_data <= buf_q[nidx];
            rsp_idx  <= nidx;
            rsp_last <= (nidx == LAST_IDX);
          end else begin
            rsp_valid <= 1'b0;
            widx      <= nidx;
            state     <= ST_ADDR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Holding registers for the words that wait behind word 0 in interleaved mode.
  always_ff @(posedge clk) begin
    if (state == ST_WAIT && ilv_q && bank_vld[0]) buf_q <= bank_dat;
  end

endmodule

// File: rtl/ilv_line_fill.sv
module ilv_line_fill #(
  parameter int LINE_AW    = 6,
  parameter int WORD_W     = 32,
  parameter int NB         = 4,
  parameter int ACCESS_LAT = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fill_req,
  input  logic [LINE_AW-1:0]    fill_line,
  input  logic                  fill_ilv,
  output logic                  fill_ready,
  output logic                  rsp_valid,
  output logic [WORD_W-1:0]     rsp_data,
  output logic [$clog2(NB)-1:0] rsp_idx,
  output logic                  rsp_last
);
  logic [NB-1:0]             bank_rd;
  logic [LINE_AW-1:0]        bank_row;
  logic [NB-1:0]             bank_vld;
  logic [NB-1:0][WORD_W-1:0] bank_dat;

  ilv_fill_ctrl #(
    .LINE_AW (LINE_AW),
    .WORD_W  (WORD_W),
    .NB      (NB)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fill_req   (fill_req),
    .fill_line  (fill_line),
    .fill_ilv   (fill_ilv),
    .fill_ready (fill_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_idx    (rsp_idx),
    .rsp_last   (rsp_last),
    .bank_rd    (bank_rd),
    .bank_row   (bank_row),
    .bank_vld   (bank_vld),
    .bank_dat   (bank_dat)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      ilv_fill_bank #(
        .ROWS_AW (LINE_AW),
        .WORD_W  (WORD_W),
        .LAT     (ACCESS_LAT),
        .NB      (NB),
        .BANK_ID (b)
      ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .rd_en (bank_rd[b]),
        .row   (bank_row),
        .vld   (bank_vld[b]),
        .dat   (bank_dat[b])
      );
    end
  endgenerate

endmodule

// File: rtl/ilv_line_fill_chk.sv
module ilv_line_fill_chk #(
  parameter int NB         = 4,
  parameter int ACCESS_LAT = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  fill_req,
  input logic                  fill_ilv,
  input logic                  fill_ready,
  input logic                  rsp_valid,
  input logic [$clog2(NB)-1:0] rsp_idx,
  input logic                  rsp_last
);
  localparam int IDX_W = $clog2(NB);
  localparam logic [15:0] ILV_SPAN = 16'(ACCESS_LAT + NB);
  localparam logic [15:0] SER_SPAN = 16'(NB * (ACCESS_LAT + 2) - 1);

  logic [15:0] since;
  logic        mode_q;

  // Edges elapsed since the last accepting edge, and the mode taken there.
  always_ff @(posedge clk) begin
    if (rst) begin
      since  <= '0;
      mode_q <= 1'b0;
    end else if (fill_req && fill_ready) begin
      since  <= '0;
      mode_q <= fill_ilv;
    end else if (since != 16'hFFFF) begin
      since  <= since + 16'd1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fill_ready && !rsp_valid && !rsp_last));

  p_ilv_span_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_last && mode_q) |-> (since == ILV_SPAN));

  p_ser_span_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_last && !mode_q) |-> (since == SER_SPAN));

  p_ser_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !mode_q) |=> !rsp_valid);

  p_last_word_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> (rsp_valid && rsp_idx == IDX_W'(NB - 1)));

  p_idx_step_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(rsp_valid)) |-> (rsp_idx == IDX_W'($past(rsp_idx) + 1'b1)));

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (fill_req && fill_ready) |=> !fill_ready);

  p_ready_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    fill_ready |-> !rsp_valid);

endmodule

bind ilv_line_fill ilv_line_fill_chk #(
  .NB         (NB),
  .ACCESS_LAT (ACCESS_LAT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fill_req   (fill_req),
  .fill_ilv   (fill_ilv),
  .fill_ready (fill_ready),
  .rsp_valid  (rsp_valid),
  .rsp_idx    (rsp_idx),
  .rsp_last   (rsp_last)
);

// File: tb/ilv_line_fill_bench.sv
module ilv_line_fill_bench;
  localparam int LINE_AW = 6;
  localparam int WORD_W  = 32;
  localparam int NB      = 4;
  localparam int LAT     = 6;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               fill_req = 1'b0;
  logic [LINE_AW-1:0] fill_line = '0;
  logic               fill_ilv = 1'b0;
  logic               fill_ready;
  logic               rsp_valid;
  logic [WORD_W-1:0]  rsp_data;
  logic [1:0]         rsp_idx;
  logic               rsp_last;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  typedef struct {
    logic [31:0] d;
    int          idx;
    bit          last;
    int          cyc;
    bit          ilv;
  } item_t;
  item_t sb[$];

  ilv_line_fill #(
    .LINE_AW(LINE_AW), .WORD_W(WORD_W), .NB(NB), .ACCESS_LAT(LAT)
  ) u_ilv_line_fill (
    .clk(clk), .rst(rst), .fill_req(fill_req), .fill_line(fill_line),
    .fill_ilv(fill_ilv), .fill_ready(fill_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_idx(rsp_idx), .rsp_last(rsp_last)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] model_word(input int line, input int w);
    int g;
    g = line * NB + w;
    return {~g[15:0], g[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Cycle counter: edges since the last accepting edge.
  always @(posedge clk) begin
    if (fill_req && fill_ready) cyc <= 0;
    else                        cyc <= cyc + 1;
  end

  // Monitor: compare each produced word with the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6", "word with no fill pending", rsp_data, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(rsp_data == it.d, "R2", "word data", rsp_data, it.d);
        chk(int'(rsp_idx) == it.idx, "R5", "word order", rsp_idx, it.idx);
        chk(rsp_last == it.last, "R5", "last marker", rsp_last, it.last);
        chk(cyc + 1 == it.cyc, it.ilv ? "R3" : "R4", "word cycle", cyc + 1, it.cyc);
      end
    end
  end

  // Driver: waits for ready, issues a fill and pushes the expected words.
  task automatic do_fill(input int line, input bit ilv, input bit poke);
    while (!fill_ready) @(negedge clk);
    fill_req  = 1'b1;
    fill_line = line[LINE_AW-1:0];
    fill_ilv  = ilv;
    for (int w = 0; w < NB; w++) begin
      item_t it;
      it.d    = model_word(line, w);
      it.idx  = w;
      it.last = (w == NB - 1);
      it.cyc  = ilv ? (LAT + 2 + w) : ((w + 1) * (LAT + 2));
      it.ilv  = ilv;
      sb.push_back(it);
    end
    @(negedge clk);
    fill_ilv = ~ilv;                         // R7: mode change after acceptance
    if (poke) begin
      fill_line = line[LINE_AW-1:0] ^ 6'h15; // R7: line change during the fill
      for (int k = 0; k < 5; k++) begin
        chk(fill_ready == 1'b0, "R6", "ready during fill", fill_ready, 0);
        @(negedge clk);
      end
    end
    fill_req = 1'b0;
  endtask

  task automatic drain;
    while (sb.size() != 0 || !fill_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(fill_ready == 1'b1, "R1", "ready in reset", fill_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "valid in reset", rsp_valid, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(fill_ready == 1'b1, "R1", "ready after reset", fill_ready, 1);
    chk(rsp_valid == 1'b0 && rsp_last == 1'b0, "R1", "outputs after reset",
        {rsp_valid, rsp_last}, 0);

    // R3: interleaved fills of several lines
    do_fill(0, 1'b1, 1'b0);  drain();
    do_fill(5, 1'b1, 1'b0);  drain();
    do_fill(63, 1'b1, 1'b0); drain();
    // R4: serial fills
    do_fill(1, 1'b0, 1'b0);  drain();
    do_fill(62, 1'b0, 1'b0); drain();
    // R6 and R7: requests held while busy are ignored
    do_fill(10, 1'b1, 1'b1); drain();
    do_fill(20, 1'b0, 1'b1); drain();
    // R8: back-to-back fills in both orders
    do_fill(7, 1'b1, 1'b0);
    do_fill(8, 1'b0, 1'b0);
    do_fill(33, 1'b1, 1'b0);
    drain();

    repeat (20) @(negedge clk);
    chk(sb.size() == 0, "R6", "words outstanding at end", sb.size(), 0);
    chk(fill_ready == 1'b1 && rsp_valid == 1'b0, "R6", "idle at end",
        {fill_ready, rsp_valid}, 2'b10);
    finish_run();
  end

endmodule